// File: doc/BRIEF.md
# I2C Multi-Message Transfer Sequencer

This block is the control layer that sits above a byte-level I2C master engine. Given a table of message descriptors (target address, 7-bit or 10-bit addressing, direction, error-skip flag, byte count) and a per-message byte buffer, it walks the messages in order. It tells the engine when to open the bus, when to reopen it, when to release it, and which address and data bytes to move. It reacts to the engine's per-byte outcome events, stores received bytes, writes a two-bit status for every message and pulses `done` when the whole transfer has been handled.

A transfer is launched through a valid/ready start port that carries the table base and the message count. The descriptor, buffer and status ports all share the message index `msg_idx`. Descriptor and buffer reads are combinational, so the table must stay stable while a transfer runs. Commands to the engine travel on a valid/ready channel. Once `cmd_valid` is raised, the command fields hold until `cmd_ready` is seen high at a clock edge. The engine may apply back-pressure for as long as it needs. Events come back without back-pressure: one event per cycle on `evt_valid`, and an event that does not fit the current wait state is dropped.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: `start_ready` is high only while the block is idle, and never while a command is pending. A start request with a message count of 0 issues no command and raises `done` for exactly one cycle.
- R2: The first message opens with `cmd_cond`=1 (start). Every later message opens with `cmd_cond`=2 (repeated start). All other commands carry `cmd_cond`=0. Any command with a non-zero condition is a send (`cmd_op`=0).
- R3: In 7-bit mode, the address byte is `desc_addr[7:1]` followed by a direction bit in bit 0: 1 for read, 0 for write.
- R4: In 10-bit mode, the first byte is 0xF0 | (`desc_addr[9:8]` << 1), always with bit 0 cleared. After its ACK, `desc_addr[7:0]` is sent. For a read, the ACK of that low byte triggers a repeated start carrying the header again with bit 0 set.
- R5: In a write, each ACK sends the buffer byte at `buf_pos` (0, 1, 2 and so on). When an ACK arrives after `desc_len` data bytes, the message status becomes 0 (OK). A write of length 0 completes on the address ACK.
- R6: A NACK of any address byte (7-bit byte, 10-bit header or 10-bit low byte) gives status 1 (no device). A NACK of a write data byte gives status 2 (no acknowledge).
- R7: The arbitration-lost event in any wait state gives status 3, and processing continues with the next message.
- R8: A read issues one receive command (`cmd_op`=1) per byte. Byte k has `cmd_nack`=1 exactly when k = `desc_len`-1. Each data event (`evt_kind`=2) is written to the buffer at position k through `buf_we`. A read of length 0 completes with status 0 when its address is ACKed.
- R9: The receive command for the final byte of the final message carries `cmd_stop`=1, and no separate stop command follows it. `cmd_stop` is only ever set together with a receive that has NACK armed.
- R10: When the messages are exhausted and the bus is still held, one stop command (`cmd_op`=2) is issued, then `done` pulses for a single cycle.
- R11: After an error, the same status is written to each following message whose skip flag is set. Processing resumes with the first later message that has no skip flag.
- R12: Events whose kind does not match the current wait state (for example a data event while a write waits for an ACK) change neither the outputs nor any buffer or status.
- R13: While `cmd_valid` is high and `cmd_ready` is low, every command field stays unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Transfer request |
| start_ready | output | 1 | Block idle and able to take a request |
| start_base | input | IDX_W | Table index of the first message |
| start_count | input | IDX_W+1 | Number of messages |
| done | output | 1 | One-cycle pulse at transfer end |
| msg_idx | output | IDX_W | Current message index for descriptor and buffer |
| desc_addr | input | 10 | Target address of the current message |
| desc_ten | input | 1 | 10-bit addressing |
| desc_rd | input | 1 | Read when 1, write when 0 |
| desc_skip | input | 1 | Inherit a previous error |
| desc_len | input | LEN_W | Byte count |
| buf_pos | output | LEN_W | Byte position in the buffer |
| buf_rdata | input | 8 | Buffer byte at msg_idx/buf_pos |
| buf_we | output | 1 | Store received byte |
| buf_wdata | output | 8 | Received byte |
| stat_we | output | 1 | Status write strobe |
| stat_idx | output | IDX_W | Message index of the status write |
| stat_code | output | 2 | 0 OK, 1 no device, 2 no ack, 3 arbitration lost |
| cmd_valid | output | 1 | Command pending |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_cond | output | 2 | 0 none, 1 start, 2 repeated start, applied before the byte |
| cmd_op | output | 2 | 0 send byte, 1 receive byte, 2 stop |
| cmd_data | output | 8 | Byte to send |
| cmd_nack | output | 1 | Reply NACK to the received byte |
| cmd_stop | output | 1 | Stop after the received byte |
| evt_valid | input | 1 | Engine event |
| evt_kind | input | 2 | 0 ACK, 1 NACK, 2 data, 3 arbitration lost |
| evt_data | input | 8 | Received byte with a data event |

## Verification
The bench builds the block with its defaults: IDX_W=4 (a 16-entry table) and LEN_W=4. It sweeps read and write lengths 0 through 5, which reaches the zero-length, single-byte and multi-byte paths of the NACK and stop arming, and uses non-zero table bases. Hand-built tables then cover a three-message chain that mixes 7-bit and 10-bit read and write, a NACK of the address, of the low 10-bit byte and of a data byte, arbitration loss with skip-flag propagation, a stray event and an empty transfer. All expected command words, statuses and buffer contents are worked out arithmetically in the bench from the descriptor table.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [1:0] {
    CND_NONE   = 2'd0,
    CND_START  = 2'd1,
    CND_RSTART = 2'd2
  } cond_e;

  typedef enum logic [1:0] {
    OP_SEND = 2'd0,
    OP_RECV = 2'd1,
    OP_STOP = 2'd2
  } op_e;

  localparam logic [1:0] EV_ACK  = 2'd0;
  localparam logic [1:0] EV_NACK = 2'd1;
  localparam logic [1:0] EV_DATA = 2'd2;
  localparam logic [1:0] EV_ARB  = 2'd3;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_NODEV = 2'd1;
  localparam logic [1:0] ST_NOACK = 2'd2;
  localparam logic [1:0] ST_ARB   = 2'd3;

  typedef struct packed {
    cond_e      cond;
    op_e        op;
    logic [7:0] data;
    logic       nack;
    logic       stop;
  } cmd_t;

  typedef enum logic [3:0] {
    S_IDLE, S_NEXT, S_ISSUE, S_HDR, S_LOW_R, S_ADDR_R,
    S_SEND, S_RECV, S_SKIP, S_FIN, S_DONE
  } state_e;

  function automatic cmd_t mk_cmd(cond_e c, op_e o, logic [7:0] d, logic n, logic s);
    cmd_t r;
    r.cond = c;
    r.op   = o;
    r.data = d;
    r.nack = n;
    r.stop = s;
    return r;
  endfunction

endpackage

// File: rtl/i2cseq_addr_gen.sv
// Builds every address byte a message may need from its descriptor.
module i2cseq_addr_gen (
  input  logic [9:0] dev,
  input  logic       rd,
  output logic [7:0] short_b,
  output logic [7:0] hdr_w,
  output logic [7:0] hdr_r,
  output logic [7:0] low_b
);
  assign short_b = {dev[7:1], rd};
  assign hdr_w   = {5'b11110, dev[9:8], 1'b0};
  assign hdr_r   = {5'b11110, dev[9:8], 1'b1};
  assign low_b   = dev[7:0];
endmodule

// File: rtl/i2cseq_rx_plan.sv
// Decides reply and stop arming for receive byte k of a message.
module i2cseq_rx_plan #(
  parameter int LEN_W = 4
) (
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] k,
  input  logic             last_msg,
  output logic             nack,
  output logic             stop
);
  localparam logic [LEN_W:0] ONE = 1;
  logic [LEN_W:0] k_plus;

  assign k_plus = {1'b0, k} + ONE;
  assign nack   = k_plus >= {1'b0, len};
  assign stop   = nack & last_msg;
endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [IDX_W-1:0] start_base,
  input  logic [IDX_W:0]   start_count,
  output logic             done,
  output logic [IDX_W-1:0] msg_idx,
  input  logic [9:0]       desc_addr,
  input  logic             desc_ten,
  input  logic             desc_rd,
  input  logic             desc_skip,
  input  logic [LEN_W-1:0] desc_len,
  output logic [LEN_W-1:0] buf_pos,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  output logic             stat_we,
  output logic [IDX_W-1:0] stat_idx,
  output logic [1:0]       stat_code,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_cond,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_nack,
  output logic             cmd_stop,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  input  logic [7:0]       evt_data
);
  localparam logic [IDX_W:0]   ONE_C = 1;
  localparam logic [LEN_W:0]   ONE_L = 1;
  localparam logic [LEN_W-1:0] ONE_P = 1;

  state_e           state_q, ret_q;
  cmd_t             cmd_q;
  logic             cmd_v_q;
  logic [IDX_W-1:0] base_q;
  logic [IDX_W:0]   cnt_q, cur_q, cur_inc;
  logic [LEN_W-1:0] pos_q, k_sel;
  logic [LEN_W:0]   pos_nx;
  logic             first_q, open_q, done_q;
  logic [1:0]       err_q;
  logic             st_we_q;
  logic [IDX_W-1:0] st_idx_q;
  logic [1:0]       st_code_q;

  logic             more, last_msg, waiting;
  logic             is_ack, is_data;
  logic             err_hit;
  logic [1:0]       err_code;
  logic [7:0]       short_b, hdr_w, hdr_r, low_b;
  logic             rx_nack, rx_stop;

  assign msg_idx  = base_q + cur_q[IDX_W-1:0];
  assign cur_inc  = cur_q + ONE_C;
  assign more     = cur_q < cnt_q;
  assign last_msg = cur_inc == cnt_q;
  assign pos_nx   = {1'b0, pos_q} + ONE_L;
  assign waiting  = (state_q == S_HDR) || (state_q == S_LOW_R) || (state_q == S_ADDR_R) ||
                    (state_q == S_SEND) || (state_q == S_RECV);
  assign is_ack   = evt_valid && (evt_kind == EV_ACK);
  assign is_data  = evt_valid && (evt_kind == EV_DATA);

  i2cseq_addr_gen u_addr (
    .dev     (desc_addr),
    .rd      (desc_rd),
    .short_b (short_b),
    .hdr_w   (hdr_w),
    .hdr_r   (hdr_r),
    .low_b   (low_b)
  );

  // first receive uses byte 0, later ones the byte after the current one
  assign k_sel = (state_q == S_ADDR_R) ? '0 : pos_q + ONE_P;

  i2cseq_rx_plan #(.LEN_W(LEN_W)) u_rx (
    .len      (desc_len),
    .k        (k_sel),
    .last_msg (last_msg),
    .nack     (rx_nack),
    .stop     (rx_stop)
  );

  // error classification for the event in the current wait state
  always_comb begin
    err_hit  = 1'b0;
    err_code = ST_OK;
    if (evt_valid && waiting) begin
      if (evt_kind == EV_ARB) begin
        err_hit  = 1'b1;
        err_code = ST_ARB;
      end else if (evt_kind == EV_NACK && state_q != S_RECV) begin
        err_hit  = 1'b1;
        err_code = (state_q == S_SEND && pos_q != '0) ? ST_NOACK : ST_NODEV;
      end
    end
  end

  assign buf_we    = is_data && (state_q == S_RECV);
  assign buf_wdata = evt_data;
  assign buf_pos   = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      ret_q     <= S_IDLE;
      cmd_q     <= mk_cmd(CND_NONE, OP_SEND, 8'h00, 1'b0, 1'b0);
      cmd_v_q   <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      cur_q     <= '0;
      pos_q     <= '0;
      first_q   <= 1'b0;
      open_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= ST_OK;
      st_we_q   <= 1'b0;
      st_idx_q  <= '0;
      st_code_q <= ST_OK;
    end else begin
      done_q  <= 1'b0;
      st_we_q <= 1'b0;
      if (err_hit) begin
        st_we_q   <= 1'b1;
        st_idx_q  <= msg_idx;
        st_code_q <= err_code;
        err_q     <= err_code;
        cur_q     <= cur_inc;
        state_q   <= S_SKIP;
      end else begin
        case (state_q)
          S_IDLE: begin
            if (start_valid) begin
              base_q  <= start_base;
              cnt_q   <= start_count;
              cur_q   <= '0;
              first_q <= 1'b1;
              state_q <= S_NEXT;
            end
          end
          S_NEXT: begin
            pos_q <= '0;
            if (!more) begin
              state_q <= S_FIN;
            end else begin
              first_q <= 1'b0;
              cmd_q   <= mk_cmd(first_q ? CND_START : CND_RSTART, OP_SEND,
                                desc_ten ? hdr_w : short_b, 1'b0, 1'b0);
              cmd_v_q <= 1'b1;
              ret_q   <= desc_ten ? S_HDR : (desc_rd ? S_ADDR_R : S_SEND);
              state_q <= S_ISSUE;
            end
          end
          S_ISSUE: begin
            if (cmd_ready) begin
              cmd_v_q <= 1'b0;
              state_q <= ret_q;
              if (cmd_q.cond == CND_START) open_q <= 1'b1;
              if (cmd_q.op == OP_STOP || cmd_q.stop) open_q <= 1'b0;
            end
          end
          S_HDR: begin
            if (is_ack) begin
              cmd_q   <= mk_cmd(CND_NONE, OP_SEND, low_b, 1'b0, 1'b0);
              cmd_v_q <= 1'b1;
              ret_q   <= desc_rd ? S_LOW_R : S_SEND;
              state_q <= S_ISSUE;
            end
          end
          S_LOW_R: begin
            if (is_ack) begin
              cmd_q   <= mk_cmd(CND_RSTART, OP_SEND, hdr_r, 1'b0, 1'b0);
              cmd_v_q <= 1'b1;
              ret_q   <= S_ADDR_R;
              state_q <= S_ISSUE;
            end
          end
          S_ADDR_R: begin
            if (is_ack) begin
              if (desc_len == '0) begin
                st_we_q   <= 1'b1;
                st_idx_q  <= msg_idx;
                st_code_q <= ST_OK;
                cur_q     <= cur_inc;
                state_q   <= S_NEXT;
              end else begin
                cmd_q   <= mk_cmd(CND_NONE, OP_RECV, 8'h00, rx_nack, rx_stop);
                cmd_v_q <= 1'b1;
                ret_q   <= S_RECV;
                state_q <= S_ISSUE;
              end
            end
          end
          S_SEND: begin
            if (is_ack) begin
              if (pos_q == desc_len) begin
                st_we_q   <= 1'b1;
                st_idx_q  <= msg_idx;
                st_code_q <= ST_OK;
                cur_q     <= cur_inc;
                state_q   <= S_NEXT;
              end else begin
                cmd_q   <= mk_cmd(CND_NONE, OP_SEND, buf_rdata, 1'b0, 1'b0);
                cmd_v_q <= 1'b1;
                pos_q   <= pos_q + ONE_P;
                ret_q   <= S_SEND;
                state_q <= S_ISSUE;
              end
            end
          end
          S_RECV: begin
            if (is_data) begin
              if (pos_nx == {1'b0, desc_len}) begin
                st_we_q   <= 1'b1;
                st_idx_q  <= msg_idx;
                st_code_q <= ST_OK;
                cur_q     <= cur_inc;
                state_q   <= S_NEXT;
              end else begin
                cmd_q   <= mk_cmd(CND_NONE, OP_RECV, 8'h00, rx_nack, rx_stop);
                cmd_v_q <= 1'b1;
                pos_q   <= pos_q + ONE_P;
                ret_q   <= S_RECV;
                state_q <= S_ISSUE;
              end
            end
          end
          S_SKIP: begin
            if (more && desc_skip) begin
              st_we_q   <= 1'b1;
              st_idx_q  <= msg_idx;
              st_code_q <= err_q;
              cur_q     <= cur_inc;
            end else begin
              state_q <= S_NEXT;
            end
          end
          S_FIN: begin
            if (open_q) begin
              cmd_q   <= mk_cmd(CND_NONE, OP_STOP, 8'h00, 1'b0, 1'b0);
              cmd_v_q <= 1'b1;
              ret_q   <= S_DONE;
              state_q <= S_ISSUE;
            end else begin
              state_q <= S_DONE;
            end
          end
          S_DONE: begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign start_ready = (state_q == S_IDLE);
  assign done        = done_q;
  assign stat_we     = st_we_q;
  assign stat_idx    = st_idx_q;
  assign stat_code   = st_code_q;
  assign cmd_valid   = cmd_v_q;
  assign cmd_cond    = cmd_q.cond;
  assign cmd_op      = cmd_q.op;
  assign cmd_data    = cmd_q.data;
  assign cmd_nack    = cmd_q.nack;
  assign cmd_stop    = cmd_q.stop;

endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_valid,
  input logic       start_ready,
  input logic       done,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_cond,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       cmd_nack,
  input logic       cmd_stop
);
  // R1: an accepted request makes the block busy on the next cycle
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> !start_ready);

  // R1: no command is pending while the block reports idle
  a_r1_idle_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !cmd_valid);

  // R2: a bus condition is always followed by a sent byte
  a_r2_cond_on_send: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_cond != 2'd0 |-> cmd_op == 2'd0);

  // R9: a pre-armed stop only rides on a receive with NACK armed
  a_r9_stop_with_nack: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_stop |-> cmd_op == 2'd1 && cmd_nack);

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13: a stalled command holds every field
  a_r13_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_cond) && $stable(cmd_op) &&
      $stable(cmd_data) && $stable(cmd_nack) && $stable(cmd_stop));
endmodule

bind i2c_msg_sequencer i2cseq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .done        (done),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_cond    (cmd_cond),
  .cmd_op      (cmd_op),
  .cmd_data    (cmd_data),
  .cmd_nack    (cmd_nack),
  .cmd_stop    (cmd_stop)
);

// File: tb/tb_i2c_msg_sequencer.sv
`timescale 1ns/1ps
module tb_i2c_msg_sequencer;
  localparam int IW = 4;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start_valid = 1'b0, start_ready, done;
  logic [IW-1:0] start_base = '0;
  logic [IW:0]   start_count = '0;
  logic [IW-1:0] msg_idx, stat_idx;
  logic [9:0]    desc_addr;
  logic          desc_ten, desc_rd, desc_skip;
  logic [LW-1:0] desc_len, buf_pos;
  logic [7:0]    buf_rdata, buf_wdata, cmd_data, evt_data;
  logic          buf_we, stat_we, cmd_valid, cmd_nack, cmd_stop;
  logic          cmd_ready = 1'b0, evt_valid = 1'b0;
  logic [1:0]    stat_code, cmd_cond, cmd_op;
  logic [1:0]    evt_kind = 2'd0;

  logic [9:0] t_addr [16];
  logic       t_ten [16], t_rd [16], t_skip [16];
  logic [3:0] t_len [16];
  logic [7:0] mem [16][16];
  int         st [16];

  assign desc_addr = t_addr[msg_idx];
  assign desc_ten  = t_ten[msg_idx];
  assign desc_rd   = t_rd[msg_idx];
  assign desc_skip = t_skip[msg_idx];
  assign desc_len  = t_len[msg_idx];
  assign buf_rdata = mem[msg_idx][buf_pos];

  always @(posedge clk) begin
    if (buf_we) mem[msg_idx][buf_pos] <= buf_wdata;
    if (stat_we) st[stat_idx] <= int'(stat_code);
  end

  i2c_msg_sequencer #(.IDX_W(IW), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_base(start_base), .start_count(start_count), .done(done),
    .msg_idx(msg_idx), .desc_addr(desc_addr), .desc_ten(desc_ten),
    .desc_rd(desc_rd), .desc_skip(desc_skip), .desc_len(desc_len),
    .buf_pos(buf_pos), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .stat_we(stat_we), .stat_idx(stat_idx), .stat_code(stat_code),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_cond(cmd_cond), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack), .cmd_stop(cmd_stop),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_data(evt_data)
  );

  int errs = 0;
  int checks = 0;
  int lg [64];
  int n_log = 0;
  int send_cnt = 0;
  int recv_cnt = 0;
  int nack_at = -1;
  int arb_at = -1;
  bit spur = 1'b0;

  // command word: cond<<12 | op<<10 | data<<2 | nack<<1 | stop
  function automatic int pk(int c, int o, int d, int n, int s);
    return (c << 12) | (o << 10) | (d << 2) | (n << 1) | s;
  endfunction

  task automatic ck(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // byte engine model
  initial begin
    evt_data = 8'h00;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        if (n_log < 64) lg[n_log] = pk(int'(cmd_cond), int'(cmd_op), int'(cmd_data),
                                       int'(cmd_nack), int'(cmd_stop));
        n_log++;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        if (lg[n_log-1][11:10] != 2'd2) begin
          if (spur) begin
            evt_valid = 1'b1; evt_kind = 2'd2; evt_data = 8'hEE;
            spur = 1'b0;
            @(negedge clk);
          end
          evt_valid = 1'b1;
          if (lg[n_log-1][11:10] == 2'd1) begin
            evt_kind = 2'd2;
            evt_data = 8'h40 + 8'(recv_cnt);
            recv_cnt++;
          end else begin
            evt_kind = (send_cnt == arb_at) ? 2'd3 : ((send_cnt == nack_at) ? 2'd1 : 2'd0);
            send_cnt++;
          end
          @(negedge clk);
          evt_valid = 1'b0;
        end
      end
    end
  end

  task automatic clear_tbl();
    for (int i = 0; i < 16; i++) begin
      t_addr[i] = '0; t_ten[i] = 1'b0; t_rd[i] = 1'b0; t_skip[i] = 1'b0; t_len[i] = '0;
      st[i] = -1;
      for (int j = 0; j < 16; j++) mem[i][j] = 8'(i * 16 + j);
    end
    nack_at = -1; arb_at = -1; spur = 1'b0;
  endtask

  task automatic run(input int base, input int count);
    bit got;
    n_log = 0; send_cnt = 0; recv_cnt = 0;
    @(negedge clk);
    start_valid = 1'b1; start_base = IW'(base); start_count = (IW+1)'(count);
    @(negedge clk);
    start_valid = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
    ck("R10 done pulse seen", int'(got), 1);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clear_tbl();
    repeat (3) @(negedge clk);
    ck("R1 reset start_ready", int'(start_ready), 1);
    ck("R1 reset cmd_valid", int'(cmd_valid), 0);
    ck("R10 reset done", int'(done), 0);
    rst_n = 1'b1;

    // R1: empty transfer
    run(3, 0);
    ck("R1 empty transfer commands", n_log, 0);

    // R3 R8 R9: 7-bit reads of length 0..5
    for (int L = 0; L <= 5; L++) begin
      clear_tbl();
      t_addr[0] = 10'h05B; t_rd[0] = 1'b1; t_len[0] = 4'(L);
      run(0, 1);
      ck("R8 read command count", n_log, (L == 0) ? 2 : L + 1);
      ck("R3 read address byte", lg[0], pk(1, 0, 8'h5B, 0, 0));
      for (int k = 0; k < L; k++) begin
        ck("R8 R9 receive nack/stop", lg[k+1], pk(0, 1, 0, int'(k == L-1), int'(k == L-1)));
        ck("R8 stored byte", int'(mem[0][k]), 8'h40 + k);
      end
      if (L == 0) ck("R10 stop after empty read", lg[1], pk(0, 2, 0, 0, 0));
      ck("R8 read status", st[0], 0);
    end

    // R3 R5 R10: 7-bit writes of length 0..5 at base 5
    for (int L = 0; L <= 5; L++) begin
      clear_tbl();
      t_addr[5] = 10'h05B; t_len[5] = 4'(L);
      for (int k = 0; k < 16; k++) mem[5][k] = 8'(8'h10 + 3 * k);
      run(5, 1);
      ck("R5 write command count", n_log, L + 2);
      ck("R3 write address byte", lg[0], pk(1, 0, 8'h5A, 0, 0));
      for (int k = 0; k < L; k++)
        ck("R5 write data byte", lg[k+1], pk(0, 0, 8'h10 + 3 * k, 0, 0));
      ck("R10 final stop", lg[L+1], pk(0, 2, 0, 0, 0));
      ck("R5 write status", st[5], 0);
    end

    // R2 R4 R9: chained messages, 7-bit write, 10-bit read, 10-bit write
    clear_tbl();
    t_addr[2] = 10'h020; t_len[2] = 4'd2;
    t_addr[3] = 10'h2C5; t_ten[3] = 1'b1; t_rd[3] = 1'b1; t_len[3] = 4'd2;
    t_addr[4] = 10'h13A; t_ten[4] = 1'b1; t_len[4] = 4'd1;
    run(2, 3);
    ck("R2 chain command count", n_log, 12);
    ck("R2 first start", lg[0], pk(1, 0, 8'h20, 0, 0));
    ck("R5 chain data0", lg[1], pk(0, 0, int'(mem[2][0]), 0, 0));
    ck("R5 chain data1", lg[2], pk(0, 0, int'(mem[2][1]), 0, 0));
    ck("R4 10-bit header write dir", lg[3], pk(2, 0, 8'hF4, 0, 0));
    ck("R4 10-bit low byte", lg[4], pk(0, 0, 8'hC5, 0, 0));
    ck("R4 10-bit read rstart header", lg[5], pk(2, 0, 8'hF5, 0, 0));
    ck("R8 chain recv0", lg[6], pk(0, 1, 0, 0, 0));
    ck("R9 no stop on non-final message", lg[7], pk(0, 1, 0, 1, 0));
    ck("R2 rstart 10-bit write", lg[8], pk(2, 0, 8'hF2, 0, 0));
    ck("R4 10-bit write low", lg[9], pk(0, 0, 8'h3A, 0, 0));
    ck("R5 10-bit write data", lg[10], pk(0, 0, int'(mem[4][0]), 0, 0));
    ck("R10 chain stop", lg[11], pk(0, 2, 0, 0, 0));
    ck("R8 chain rx byte0", int'(mem[3][0]), 8'h40);
    ck("R8 chain rx byte1", int'(mem[3][1]), 8'h41);
    ck("R5 chain status sum", st[2] + st[3] + st[4], 0);

    // R6 R11: data NACK with skip propagation
    clear_tbl();
    t_addr[0] = 10'h030; t_len[0] = 4'd2;
    t_skip[1] = 1'b1; t_len[1] = 4'd1;
    t_skip[2] = 1'b1;
    t_addr[3] = 10'h031; t_rd[3] = 1'b1; t_len[3] = 4'd1;
    nack_at = 1;
    run(0, 4);
    ck("R6 data nack status", st[0], 2);
    ck("R11 skipped status 1", st[1], 2);
    ck("R11 skipped status 2", st[2], 2);
    ck("R11 resumed status", st[3], 0);
    ck("R11 command count", n_log, 4);
    ck("R11 resume rstart", lg[2], pk(2, 0, 8'h31, 0, 0));
    ck("R9 final recv stop", lg[3], pk(0, 1, 0, 1, 1));

    // R6: address NACK, next message not skipped
    clear_tbl();
    t_addr[0] = 10'h050; t_rd[0] = 1'b1; t_len[0] = 4'd3;
    t_addr[1] = 10'h060;
    nack_at = 0;
    run(0, 2);
    ck("R6 address nack status", st[0], 1);
    ck("R11 unskipped next status", st[1], 0);
    ck("R6 address nack commands", n_log, 3);
    ck("R2 rstart after error", lg[1], pk(2, 0, 8'h60, 0, 0));

    // R6: 10-bit low byte NACK
    clear_tbl();
    t_addr[7] = 10'h3FF; t_ten[7] = 1'b1; t_len[7] = 4'd2;
    nack_at = 1;
    run(7, 1);
    ck("R6 10-bit low nack status", st[7], 1);
    ck("R4 header for 0x3FF", lg[0], pk(1, 0, 8'hF6, 0, 0));
    ck("R6 10-bit nack commands", n_log, 3);

    // R7 R11: arbitration lost on second data byte
    clear_tbl();
    t_addr[0] = 10'h070; t_len[0] = 4'd3;
    t_skip[1] = 1'b1; t_len[1] = 4'd2;
    arb_at = 2;
    run(0, 2);
    ck("R7 arbitration status", st[0], 3);
    ck("R11 arbitration propagated", st[1], 3);
    ck("R7 commands until stop", n_log, 4);
    ck("R10 stop after arbitration", lg[3], pk(0, 2, 0, 0, 0));

    // R12: stray data event while a write waits for ACK
    clear_tbl();
    t_addr[0] = 10'h022; t_len[0] = 4'd1;
    spur = 1'b1;
    run(0, 1);
    ck("R12 buffer untouched", int'(mem[0][0]), 8'h00);
    ck("R12 command count", n_log, 3);
    ck("R12 data byte still sent", lg[1], pk(0, 0, 8'h00, 0, 0));
    ck("R12 status", st[0], 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule